// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block sits between a host that builds Ethernet frame bodies and the byte-wide side of a transmit PHY adapter. The host streams the frame body as bytes: destination address, source address, type/length and payload. A start marker flags the first byte and an end marker flags the last. The block puts a preamble and a start delimiter in front of the body. It pads short bodies with zeros up to the minimum size, and it appends a 32-bit frame check sequence computed over the body and the padding. The result leaves as a byte stream with valid, last and a ready handshake.

Two per-frame options are captured when a frame starts. With CRC generation off, the host has already placed its own check bytes at the end of its data. The block then forwards that data unchanged after the preamble and adds nothing. With padding off, a short body goes straight to the check sequence. A body longer than the legal maximum is cut off at the limit and raises an error pulse. Its remaining input is drained and never completed, so no receiver accepts it.

The block holds no frame buffer. Body bytes go straight through a single output register. The host therefore sees its ready signal drop whenever the block produces bytes of its own.

Top module: `eth_tx_framer`

## Requirements
- R1: Every frame on the output begins with seven bytes of 0x55 followed by the delimiter byte 0xD5 (bit pattern 10101011 when sent least significant bit first).
- R2: Body bytes appear on the output unchanged and in input order, directly after the delimiter.
- R3: With padding and CRC both enabled, a body shorter than MIN_BODY (60) bytes is followed by 0x00 bytes until body plus padding equals MIN_BODY. A body of MIN_BODY bytes or more gets no padding.
- R4: With CRC enabled, four check bytes follow the body and padding. They hold the complement of a reflected CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF) over every body and pad byte, sent least significant byte first. Preamble and delimiter are not covered.
- R5: out_last is high on exactly one byte per completed frame. With CRC enabled that byte is the fourth check byte. With CRC disabled it is the final input byte.
- R6: With CRC disabled, the input bytes follow the delimiter unchanged and nothing is appended. pad_en has no effect in this mode.
- R7: With CRC enabled and padding disabled, the check bytes follow a short body directly.
- R8: With CRC enabled, the limit is MAX_BODY (1514) bytes; with CRC disabled it is MAX_BODY+4. Any input byte beyond the limit is not forwarded. It causes a one-cycle pulse on err_oversize, and no check bytes and no out_last are produced for that frame. All remaining input bytes up to the end marker are consumed and discarded.
- R9: in_ready is low while preamble, delimiter, pad or check bytes are being produced.
- R10: While out_valid is high and out_ready low, out_data, out_last and out_valid hold their values.
- R11: After reset, out_valid, in_ready and err_oversize are low.
- R12: pad_en and crc_en are sampled with the start-marked byte. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_en | input | 1 | Enable zero padding to minimum size (sampled at frame start) |
| crc_en | input | 1 | Enable check sequence generation (sampled at frame start) |
| in_data | input | 8 | Body byte from host |
| in_valid | input | 1 | in_data is valid |
| in_sop | input | 1 | Current byte is the first of a frame |
| in_eop | input | 1 | Current byte is the last of a frame |
| in_ready | output | 1 | Block accepts the current input byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | out_data is valid |
| out_last | output | 1 | Final byte of a completed frame |
| out_ready | input | 1 | Downstream accepts the output byte |
| err_oversize | output | 1 | One-cycle pulse when a body exceeds the limit |

## Verification
The first preamble byte reaches the output register two clock edges after a start-marked byte is presented. An accepted body byte sits in the output register from the same edge that accepts it. Pad and check bytes follow one per edge while out_ready is high, and err_oversize rises on the edge that accepts the first excess byte. The scoreboard compares only the order of transferred bytes, and it samples in mid-cycle where out_valid and out_ready are both high. Its checks therefore hold under any pattern of backpressure and input bubbles. The in_ready and err_oversize checks sample at the same mid-cycle point.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_DROP
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [7:0]  PAD_BYTE      = 8'h00;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
  import eth_tx_pkg::*;
#(
  parameter logic [31:0] POLY = CRC_POLY_REFL,
  parameter logic [31:0] INIT = CRC_INIT
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  logic [31:0] crc_nxt;

  // one byte, least significant bit first
  always_comb begin
    crc_nxt = crc_q;
    for (int b = 0; b < 8; b++) begin
      logic fb;
      fb      = crc_nxt[0] ^ din[b];
      crc_nxt = {1'b0, crc_nxt[31:1]};
      if (fb) crc_nxt = crc_nxt ^ POLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= INIT;
    else if (upd)    crc_q <= crc_nxt;
  end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int MAX_BODY = 1514
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        pad_en,
  input  logic        crc_en,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        in_ready,
  input  logic [31:0] crc_q,
  output logic        crc_init,
  output logic        crc_upd,
  output logic [7:0]  crc_din,
  output logic        emit,
  output logic [7:0]  emit_data,
  output logic        emit_last,
  output logic        err
);

  localparam int CNT_W = $clog2(MAX_BODY + 5) + 1;
  localparam int SUB_W = ($clog2(PRE_LEN) > 2) ? $clog2(PRE_LEN) : 2;

  tx_state_e          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [SUB_W-1:0]   sub_q, sub_n;
  logic               cfg_pad_q, cfg_pad_n;
  logic               cfg_crc_q, cfg_crc_n;
  logic [CNT_W-1:0]   limit;
  logic [CNT_W-1:0]   cnt_inc;
  logic [31:0]        fcs_word;

  assign limit    = cfg_crc_q ? CNT_W'(MAX_BODY) : CNT_W'(MAX_BODY + 4);
  assign cnt_inc  = cnt_q + 1'b1;
  assign fcs_word = ~crc_q >> {sub_q[1:0], 3'b000};

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    sub_n     = sub_q;
    cfg_pad_n = cfg_pad_q;
    cfg_crc_n = cfg_crc_q;
    in_ready  = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_din   = in_data;
    emit      = 1'b0;
    emit_data = PAD_BYTE;
    emit_last = 1'b0;
    err       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid && in_sop) begin
          crc_init  = 1'b1;
          cfg_pad_n = pad_en;
          cfg_crc_n = crc_en;
          cnt_n     = '0;
          sub_n     = '0;
          st_n      = ST_PRE;
        end
      end
      ST_PRE: begin
        if (load) begin
          emit      = 1'b1;
          emit_data = PRE_BYTE;
          if (sub_q == SUB_W'(PRE_LEN - 1)) st_n  = ST_SFD;
          else                              sub_n = sub_q + 1'b1;
        end
      end
      ST_SFD: begin
        if (load) begin
          emit      = 1'b1;
          emit_data = SFD_BYTE;
          st_n      = ST_BODY;
        end
      end
      ST_BODY: begin
        in_ready = load;
        if (in_valid && load) begin
          if (cnt_q == limit) begin
            err  = 1'b1;
            st_n = in_eop ? ST_IDLE : ST_DROP;
          end else begin
            emit      = 1'b1;
            emit_data = in_data;
            crc_upd   = cfg_crc_q;
            cnt_n     = cnt_inc;
            if (in_eop) begin
              sub_n = '0;
              if (!cfg_crc_q) begin
                emit_last = 1'b1;
                st_n      = ST_IDLE;
              end else if (cfg_pad_q && (cnt_inc < CNT_W'(MIN_BODY))) begin
                st_n = ST_PAD;
              end else begin
                st_n = ST_FCS;
              end
            end
          end
        end
      end
      ST_PAD: begin
        if (load) begin
          emit      = 1'b1;
          emit_data = PAD_BYTE;
          crc_upd   = 1'b1;
          crc_din   = PAD_BYTE;
          cnt_n     = cnt_inc;
          if (cnt_inc == CNT_W'(MIN_BODY)) st_n = ST_FCS;
        end
      end
      ST_FCS: begin
        if (load) begin
          emit      = 1'b1;
          emit_data = fcs_word[7:0];
          if (sub_q[1:0] == 2'd3) begin
            emit_last = 1'b1;
            st_n      = ST_IDLE;
          end else begin
            sub_n = sub_q + 1'b1;
          end
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eop) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sub_q     <= '0;
      cfg_pad_q <= 1'b0;
      cfg_crc_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      sub_q     <= sub_n;
      cfg_pad_q <= cfg_pad_n;
      cfg_crc_q <= cfg_crc_n;
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int MAX_BODY = 1514
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pad_en,
  input  logic       crc_en,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  input  logic       out_ready,
  output logic       err_oversize
);

  logic        load;
  logic        emit, emit_last, err;
  logic [7:0]  emit_data;
  logic        crc_init, crc_upd;
  logic [7:0]  crc_din;
  logic [31:0] crc_q;

  assign load = !out_valid || out_ready;

  eth_tx_seq #(
    .PRE_LEN (PRE_LEN),
    .MIN_BODY(MIN_BODY),
    .MAX_BODY(MAX_BODY)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .pad_en   (pad_en),
    .crc_en   (crc_en),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_ready (in_ready),
    .crc_q    (crc_q),
    .crc_init (crc_init),
    .crc_upd  (crc_upd),
    .crc_din  (crc_din),
    .emit     (emit),
    .emit_data(emit_data),
    .emit_last(emit_last),
    .err      (err)
  );

  eth_tx_crc32 u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (crc_init),
    .upd  (crc_upd),
    .din  (crc_din),
    .crc_q(crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_last     <= 1'b0;
      err_oversize <= 1'b0;
    end else begin
      err_oversize <= err;
      if (load) begin
        out_valid <= emit;
        out_data  <= emit_data;
        out_last  <= emit_last;
      end
    end
  end

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_ready,
  input logic       err_oversize
);

  // R10: a stalled output byte stays put
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R5: the last flag only rides on a valid byte
  assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R8: the oversize flag is a single-cycle pulse
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    err_oversize |=> !err_oversize);

  // R9: once a frame closes, no body byte is taken before a new preamble
  assert_ready_gap_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !in_ready);

  // R11: reset clears the output side
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> !out_valid && !err_oversize && !out_last);

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_last    (out_last),
  .out_ready   (out_ready),
  .err_oversize(err_oversize)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

  localparam int MIN_BODY = 60;
  localparam int MAX_BODY = 1514;
  localparam int K_PRE = 0, K_SFD = 1, K_BODY = 2, K_PAD = 3, K_FCS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pad_en = 1'b0, crc_en = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid, out_last;
  logic       out_ready = 1'b0;
  logic       err_oversize;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_err  = 0;
  int got_err  = 0;
  logic [11:0] exp_q[$];
  string       req_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit          stall_on = 1'b0;

  always #4 clk = ~clk;

  eth_tx_framer u_dut (
    .clk(clk), .rst(rst), .pad_en(pad_en), .crc_en(crc_en),
    .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready), .err_oversize(err_oversize)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic push(int kind, bit last, logic [7:0] d, string req);
    exp_q.push_back({3'(kind), last, d});
    req_q.push_back(req);
  endtask

  // downstream backpressure
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_on ? lfsr[3] | lfsr[7] : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        if (err_oversize) got_err++;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R8", "unexpected output byte", int'(out_data), 0);
          end else begin
            logic [11:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(out_data == e[7:0], r, "data", int'(out_data), int'(e[7:0]));
            check(out_last == e[8], "R5", "last flag", int'(out_last), int'(e[8]));
            if (e[11:9] == 3'(K_PRE) || e[11:9] == 3'(K_PAD) || e[11:9] == 3'(K_FCS))
              check(!in_ready, "R9", "in_ready during generated byte", int'(in_ready), 0);
          end
        end
      end
    end
  end

  task automatic send_frame(int len, bit pad, bit crc, bit flip, int seed);
    int limit;
    int n_emit;
    logic [31:0] c;
    logic [7:0] b;
    limit  = crc ? MAX_BODY : MAX_BODY + 4;
    n_emit = (len > limit) ? limit : len;
    c      = 32'hFFFFFFFF;
    for (int i = 0; i < 7; i++) push(K_PRE, 0, 8'h55, "R1");
    push(K_SFD, 0, 8'hD5, "R1");
    for (int i = 0; i < n_emit; i++) begin
      b = 8'(seed + i * 7);
      c = crc_step(c, b);
      push(K_BODY, (!crc && i == len - 1), b, crc ? "R2" : "R6");
    end
    if (len > limit) begin
      exp_err++;
    end else if (crc) begin
      if (pad) for (int i = len; i < MIN_BODY; i++) begin
        c = crc_step(c, 8'h00);
        push(K_PAD, 0, 8'h00, flip ? "R12" : "R3");
      end
      c = ~c;
      for (int i = 0; i < 4; i++) push(K_FCS, i == 3, c[i*8 +: 8], pad ? "R4" : "R7");
    end
    // drive
    @(negedge clk);
    pad_en = pad;
    crc_en = crc;
    for (int i = 0; i < len; i++) begin
      bit hs;
      if (((i + seed) % 5) == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_data  = 8'(seed + i * 7);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      if (flip && i == 1) begin
        pad_en = ~pad;
        crc_en = ~crc;
      end
      hs = 1'b0;
      while (!hs) begin
        #3;
        hs = in_ready;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    check(!out_valid, "R11", "out_valid after reset", int'(out_valid), 0);
    check(!in_ready, "R11", "in_ready after reset", int'(in_ready), 0);
    check(!err_oversize, "R11", "err after reset", int'(err_oversize), 0);
    @(negedge clk);
    rst = 1'b0;
    send_frame(64, 1, 1, 0, 8'h10);    // R2 R4 no pad needed
    send_frame(20, 1, 1, 0, 8'h21);    // R3 pad to 60
    stall_on = 1'b1;
    send_frame(59, 1, 1, 0, 8'h32);    // R3 one pad byte
    send_frame(60, 1, 1, 0, 8'h43);    // R3 boundary, no pad
    send_frame(20, 0, 1, 0, 8'h54);    // R7
    send_frame(30, 1, 0, 0, 8'h65);    // R6 pad ignored
    send_frame(25, 1, 1, 1, 8'h76);    // R12 config change mid-frame
    send_frame(MAX_BODY + 3, 1, 1, 0, 8'h87); // R8 oversize
    send_frame(40, 1, 1, 0, 8'h98);    // recovery after R8
    stall_on = 1'b0;
    send_frame(MAX_BODY, 1, 1, 0, 8'hA9); // largest legal body, R4
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
    check(got_err == exp_err, "R8", "oversize pulses", got_err, exp_err);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule